// File: doc/BRIEF.md
# Fan Controller Register Pointer and Storage

This block holds the control registers of a six-fan controller and the pointer logic that a serial management bus uses to reach them. It sits behind an already decoded byte stream: a one-cycle pulse marks the start of a write transaction, a write strobe delivers each written byte, and a read strobe requests one byte, which comes back on the next cycle. The first byte written after a start selects the register address. All later bytes access registers. Writes step the address inside the current aligned eight-byte row. Reads step it linearly across the full 256-byte space.

The stored registers are driven straight onto outputs for the fan control logic. These cover the global and per-fan settings, fault status and fault masks, PWM targets, target counts and windows. The measured tachometer counts and the present duty cycles come in from the fan logic. They can be read through the same map, but they cannot be written. An attempt to write anywhere that cannot be written is dropped, and it raises an error flag that stays set until the next write transaction begins.

Top module: `fanctl_regfile`

## Requirements
- R1: After reset, global config is 0x20, PWM frequency is 0x44, every fan dynamics register is 0x4C, failed-fan options is 0x45, every PWM target is 0x4000, every target count is 0x3D60, and all other stored registers are 0x00. The pointer is 0x00 and counts as newly loaded.
- R2: The first byte written after `xfer_start` loads the pointer. It is not stored in any register.
- R3: The first access after the pointer is loaded uses the pointer value itself. Every later access first advances the pointer and then uses the new value.
- R4: On a write, the pointer advances inside its aligned eight-byte row. Bits 7:3 are kept, and bits 2:0 count up modulo 8, so 0x07 is followed by 0x00.
- R5: On a read, the pointer advances by one modulo 256, so 0xFF is followed by 0x00.
- R6: Address map: global config 0x00, PWM frequency 0x01, fan config 0x02+n, fan dynamics 0x08+n, fault status 2 at 0x10, fault status 1 at 0x11, fault mask 2 at 0x12, fault mask 1 at 0x13, failed-fan options 0x14, tach count 0x18+2t, duty cycle 0x30+2n, PWM target 0x40+2n, target count 0x50+2n, window 0x60+n, with n in 0..5 and t in 0..11. `fault_status` and `fault_mask` present {reg 2, reg 1}.
- R7: Each 16-bit register keeps its high byte at the even address and its low byte at the odd address. Writing one byte leaves the other byte unchanged.
- R8: The 11-bit tach count is read-only and reads back left-aligned. The even address returns count[10:3], and the odd address returns {count[2:0], 5'b0}.
- R9: The 9-bit duty cycle is read-only and reads back shifted left by 7. The even address returns duty[8:1], and the odd address returns {duty[0], 7'b0}.
- R10: A read from an address outside the map returns 0xFF.
- R11: A write to a read-only or unmapped address changes no register and sets `acc_err`. The flag stays set through later writes and clears when the next `xfer_start` arrives.
- R12: `rbyte` and `rbyte_vld` are registered. `rbyte_vld` is high exactly in the cycle after a cycle with `rbyte_en` high, and `rbyte` then holds the addressed byte.
- R13: A register output shows a written value from the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Pulse marking the start of a write transaction |
| wbyte_en | input | 1 | Write byte strobe |
| wbyte | input | 8 | Write byte data |
| rbyte_en | input | 1 | Read byte request (ignored while wbyte_en is high) |
| rbyte | output | 8 | Read byte data, registered |
| rbyte_vld | output | 1 | rbyte valid |
| acc_err | output | 1 | Sticky error flag for the current transaction |
| tach_i | input | 132 | Twelve 11-bit tach counts, tach t at [t*11 +: 11] |
| duty_i | input | 54 | Six 9-bit present duty cycles, fan n at [n*9 +: 9] |
| glob_cfg | output | 8 | Global configuration |
| pwm_freq | output | 8 | PWM frequency setting |
| fan_cfg | output | 48 | Fan configuration, fan n at [n*8 +: 8] |
| fan_dyn | output | 48 | Fan dynamics, fan n at [n*8 +: 8] |
| fault_status | output | 16 | {status 2, status 1} |
| fault_mask | output | 16 | {mask 2, mask 1} |
| fail_opt | output | 8 | Failed-fan options |
| pwm_tgt | output | 96 | PWM targets, fan n at [n*16 +: 16] |
| cnt_tgt | output | 96 | Target counts, fan n at [n*16 +: 16] |
| win | output | 48 | Windows, fan n at [n*8 +: 8] |

## Verification
The hardest cases to reach from the ports are the ones where write and read stepping differ. These are a burst of writes that crosses the end of an eight-byte row and lands back at the row start, and a read burst that crosses from 0xFF to 0x00. The stimulus loads the pointer near 0x07, inside the fan dynamics row, and at 0xFE, then keeps the burst going past the boundary. It confirms where each byte landed through the register outputs and through read-back. A burst that passes over unmapped bytes inside a row is used to show that the error flag stays set while later valid writes still take effect.

// File: rtl/fanctl_pkg.sv
package fanctl_pkg;

  localparam logic [7:0] A_GCFG  = 8'h00;
  localparam logic [7:0] A_PFREQ = 8'h01;
  localparam logic [7:0] A_FCFG  = 8'h02;
  localparam logic [7:0] A_FDYN  = 8'h08;
  localparam logic [7:0] A_FST2  = 8'h10;
  localparam logic [7:0] A_FST1  = 8'h11;
  localparam logic [7:0] A_FMSK2 = 8'h12;
  localparam logic [7:0] A_FMSK1 = 8'h13;
  localparam logic [7:0] A_FOPT  = 8'h14;
  localparam logic [7:0] A_TACH  = 8'h18;
  localparam logic [7:0] A_DUTY  = 8'h30;
  localparam logic [7:0] A_PWMT  = 8'h40;
  localparam logic [7:0] A_TCNT  = 8'h50;
  localparam logic [7:0] A_WIN   = 8'h60;

  localparam logic [7:0]  RST_GCFG  = 8'h20;
  localparam logic [7:0]  RST_PFREQ = 8'h44;
  localparam logic [7:0]  RST_FDYN  = 8'h4C;
  localparam logic [7:0]  RST_FOPT  = 8'h45;
  localparam logic [15:0] RST_PWMT  = 16'h4000;
  localparam logic [15:0] RST_TCNT  = 16'h3D60;

  function automatic logic in_span(input logic [7:0] a, input logic [7:0] base, input int n);
    return (int'(a) >= int'(base)) && (int'(a) < int'(base) + n);
  endfunction

  function automatic logic is_wr(input logic [7:0] a, input int nf);
    return (a == A_GCFG) || (a == A_PFREQ) || in_span(a, A_FCFG, nf) ||
           in_span(a, A_FDYN, nf) || in_span(a, A_FST2, 5) ||
           in_span(a, A_PWMT, 2 * nf) || in_span(a, A_TCNT, 2 * nf) ||
           in_span(a, A_WIN, nf);
  endfunction

  function automatic logic is_rd(input logic [7:0] a, input int nf, input int nt);
    return is_wr(a, nf) || in_span(a, A_TACH, 2 * nt) || in_span(a, A_DUTY, 2 * nf);
  endfunction

  function automatic logic [7:0] row_step(input logic [7:0] a);
    return {a[7:3], a[2:0] + 3'd1};
  endfunction

endpackage

// File: rtl/fanctl_ptr.sv
module fanctl_ptr
  import fanctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       xfer_start,
  input  logic       wbyte_en,
  input  logic [7:0] wbyte,
  input  logic       rbyte_en,
  output logic       acc_wr,
  output logic       acc_rd,
  output logic [7:0] acc_addr
);

  logic [7:0] ptr_q;
  logic       fresh_q;
  logic       want_q;
  logic       want;
  logic       load;

  always_comb begin
    want     = want_q | xfer_start;
    load     = wbyte_en & want;
    acc_wr   = wbyte_en & ~want;
    acc_rd   = rbyte_en & ~wbyte_en;
    if (fresh_q)     acc_addr = ptr_q;
    else if (acc_wr) acc_addr = row_step(ptr_q);
    else             acc_addr = ptr_q + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= 8'h00;
      fresh_q <= 1'b1;
      want_q  <= 1'b0;
    end else if (load) begin
      ptr_q   <= wbyte;
      fresh_q <= 1'b1;
      want_q  <= 1'b0;
    end else begin
      if (xfer_start) want_q <= 1'b1;
      if (acc_wr || acc_rd) begin
        ptr_q   <= acc_addr;
        fresh_q <= 1'b0;
      end
    end
  end

  // R2: pointer byte is never also a register access
  a_r2_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load, acc_wr, acc_rd}));

  // R3: a loaded pointer is used unchanged by the next access
  a_r3_load_fresh: assert property (@(posedge clk) disable iff (rst)
    load |=> (fresh_q && ptr_q == $past(wbyte)));

  // R4: write stepping stays in the row
  a_r4_row_keep: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && !fresh_q) |=> (ptr_q[7:3] == $past(ptr_q[7:3])));

  // R5: read stepping is linear modulo 256
  a_r5_linear: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && !fresh_q) |=> (ptr_q == $past(ptr_q) + 8'd1));

endmodule

// File: rtl/fanctl_regs.sv
module fanctl_regs
  import fanctl_pkg::*;
#(
  parameter int NFAN = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 xfer_start,
  input  logic                 acc_wr,
  input  logic [7:0]           acc_addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           glob_cfg,
  output logic [7:0]           pwm_freq,
  output logic [NFAN*8-1:0]    fan_cfg,
  output logic [NFAN*8-1:0]    fan_dyn,
  output logic [15:0]          fault_status,
  output logic [15:0]          fault_mask,
  output logic [7:0]           fail_opt,
  output logic [NFAN*16-1:0]   pwm_tgt,
  output logic [NFAN*16-1:0]   cnt_tgt,
  output logic [NFAN*8-1:0]    win,
  output logic                 acc_err
);

  logic [7:0]  gcfg_q, pfreq_q, fst2_q, fst1_q, fmsk2_q, fmsk1_q, fopt_q;
  logic [7:0]  fcfg_q [NFAN];
  logic [7:0]  fdyn_q [NFAN];
  logic [7:0]  win_q  [NFAN];
  logic [15:0] pwmt_q [NFAN];
  logic [15:0] tcnt_q [NFAN];
  logic        err_q;
  logic        bad_wr;

  assign bad_wr = acc_wr && !is_wr(acc_addr, NFAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      gcfg_q  <= RST_GCFG;
      pfreq_q <= RST_PFREQ;
      fst2_q  <= 8'h00;
      fst1_q  <= 8'h00;
      fmsk2_q <= 8'h00;
      fmsk1_q <= 8'h00;
      fopt_q  <= RST_FOPT;
      for (int f = 0; f < NFAN; f++) begin
        fcfg_q[f] <= 8'h00;
        fdyn_q[f] <= RST_FDYN;
        win_q[f]  <= 8'h00;
        pwmt_q[f] <= RST_PWMT;
        tcnt_q[f] <= RST_TCNT;
      end
    end else if (acc_wr) begin
      if (acc_addr == A_GCFG)  gcfg_q  <= wdata;
      if (acc_addr == A_PFREQ) pfreq_q <= wdata;
      if (acc_addr == A_FST2)  fst2_q  <= wdata;
      if (acc_addr == A_FST1)  fst1_q  <= wdata;
      if (acc_addr == A_FMSK2) fmsk2_q <= wdata;
      if (acc_addr == A_FMSK1) fmsk1_q <= wdata;
      if (acc_addr == A_FOPT)  fopt_q  <= wdata;
      for (int f = 0; f < NFAN; f++) begin
        if (acc_addr == A_FCFG + 8'(f))         fcfg_q[f] <= wdata;
        if (acc_addr == A_FDYN + 8'(f))         fdyn_q[f] <= wdata;
        if (acc_addr == A_WIN + 8'(f))          win_q[f]  <= wdata;
        if (acc_addr == A_PWMT + 8'(2 * f))     pwmt_q[f][15:8] <= wdata;
        if (acc_addr == A_PWMT + 8'(2 * f + 1)) pwmt_q[f][7:0]  <= wdata;
        if (acc_addr == A_TCNT + 8'(2 * f))     tcnt_q[f][15:8] <= wdata;
        if (acc_addr == A_TCNT + 8'(2 * f + 1)) tcnt_q[f][7:0]  <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             err_q <= 1'b0;
    else if (xfer_start) err_q <= 1'b0;
    else if (bad_wr)     err_q <= 1'b1;
  end

  assign glob_cfg     = gcfg_q;
  assign pwm_freq     = pfreq_q;
  assign fault_status = {fst2_q, fst1_q};
  assign fault_mask   = {fmsk2_q, fmsk1_q};
  assign fail_opt     = fopt_q;
  assign acc_err      = err_q;

  genvar g;
  generate
    for (g = 0; g < NFAN; g++) begin : g_flat
      assign fan_cfg[g*8 +: 8]   = fcfg_q[g];
      assign fan_dyn[g*8 +: 8]   = fdyn_q[g];
      assign win[g*8 +: 8]       = win_q[g];
      assign pwm_tgt[g*16 +: 16] = pwmt_q[g];
      assign cnt_tgt[g*16 +: 16] = tcnt_q[g];
    end
  endgenerate

  logic [NFAN*56+56-1:0] state_vec;
  assign state_vec = {glob_cfg, pwm_freq, fan_cfg, fan_dyn, fault_status,
                      fault_mask, fail_opt, pwm_tgt, cnt_tgt, win};

  // R1: reset values visible once reset ends
  a_r1_reset_vals: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (glob_cfg == RST_GCFG && pwm_freq == RST_PFREQ &&
                    fail_opt == RST_FOPT && fault_mask == 16'h0000));

  // R11: dropped write leaves all storage untouched
  a_r11_drop: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> $stable(state_vec));

  // R11: flag raised by a dropped write
  a_r11_flag: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> acc_err);

  // R11: flag cleared by a new transaction
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !acc_err);

  // R13: no storage change without a write strobe
  a_r13_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_wr |=> $stable(state_vec));

endmodule

// File: rtl/fanctl_rdmux.sv
module fanctl_rdmux
  import fanctl_pkg::*;
#(
  parameter int NFAN   = 6,
  parameter int NTACH  = 12,
  parameter int TACH_W = 11,
  parameter int DUTY_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_rd,
  input  logic [7:0]              acc_addr,
  input  logic [NTACH*TACH_W-1:0] tach_i,
  input  logic [NFAN*DUTY_W-1:0]  duty_i,
  input  logic [7:0]              glob_cfg,
  input  logic [7:0]              pwm_freq,
  input  logic [NFAN*8-1:0]       fan_cfg,
  input  logic [NFAN*8-1:0]       fan_dyn,
  input  logic [15:0]             fault_status,
  input  logic [15:0]             fault_mask,
  input  logic [7:0]              fail_opt,
  input  logic [NFAN*16-1:0]      pwm_tgt,
  input  logic [NFAN*16-1:0]      cnt_tgt,
  input  logic [NFAN*8-1:0]       win,
  output logic [7:0]              rbyte,
  output logic                    rbyte_vld
);

  localparam int TACH_SH = 16 - TACH_W;
  localparam int DUTY_SH = 16 - DUTY_W;

  logic [15:0] tach_al [NTACH];
  logic [15:0] duty_al [NFAN];
  logic [7:0]  rd_next;

  genvar g;
  generate
    for (g = 0; g < NTACH; g++) begin : g_tach
      assign tach_al[g] = {tach_i[g*TACH_W +: TACH_W], {TACH_SH{1'b0}}};
    end
    for (g = 0; g < NFAN; g++) begin : g_duty
      assign duty_al[g] = {duty_i[g*DUTY_W +: DUTY_W], {DUTY_SH{1'b0}}};
    end
  endgenerate

  always_comb begin
    rd_next = 8'hFF;
    if (acc_addr == A_GCFG)  rd_next = glob_cfg;
    if (acc_addr == A_PFREQ) rd_next = pwm_freq;
    if (acc_addr == A_FST2)  rd_next = fault_status[15:8];
    if (acc_addr == A_FST1)  rd_next = fault_status[7:0];
    if (acc_addr == A_FMSK2) rd_next = fault_mask[15:8];
    if (acc_addr == A_FMSK1) rd_next = fault_mask[7:0];
    if (acc_addr == A_FOPT)  rd_next = fail_opt;
    for (int f = 0; f < NFAN; f++) begin
      if (acc_addr == A_FCFG + 8'(f))         rd_next = fan_cfg[f*8 +: 8];
      if (acc_addr == A_FDYN + 8'(f))         rd_next = fan_dyn[f*8 +: 8];
      if (acc_addr == A_WIN + 8'(f))          rd_next = win[f*8 +: 8];
      if (acc_addr == A_PWMT + 8'(2 * f))     rd_next = pwm_tgt[f*16+8 +: 8];
      if (acc_addr == A_PWMT + 8'(2 * f + 1)) rd_next = pwm_tgt[f*16 +: 8];
      if (acc_addr == A_TCNT + 8'(2 * f))     rd_next = cnt_tgt[f*16+8 +: 8];
      if (acc_addr == A_TCNT + 8'(2 * f + 1)) rd_next = cnt_tgt[f*16 +: 8];
      if (acc_addr == A_DUTY + 8'(2 * f))     rd_next = duty_al[f][15:8];
      if (acc_addr == A_DUTY + 8'(2 * f + 1)) rd_next = duty_al[f][7:0];
    end
    for (int t = 0; t < NTACH; t++) begin
      if (acc_addr == A_TACH + 8'(2 * t))     rd_next = tach_al[t][15:8];
      if (acc_addr == A_TACH + 8'(2 * t + 1)) rd_next = tach_al[t][7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbyte     <= 8'h00;
      rbyte_vld <= 1'b0;
    end else begin
      rbyte_vld <= acc_rd;
      if (acc_rd) rbyte <= rd_next;
    end
  end

  // R12: one valid per request, one cycle later
  a_r12_vld_follow: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> rbyte_vld);
  a_r12_vld_quiet: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> !rbyte_vld);

  // R10: unmapped read returns all ones
  a_r10_unmapped: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && !is_rd(acc_addr, NFAN, NTACH)) |=> (rbyte == 8'hFF));

endmodule

// File: rtl/fanctl_regfile.sv
module fanctl_regfile
  import fanctl_pkg::*;
#(
  parameter int NFAN   = 6,
  parameter int NTACH  = 12,
  parameter int TACH_W = 11,
  parameter int DUTY_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    xfer_start,
  input  logic                    wbyte_en,
  input  logic [7:0]              wbyte,
  input  logic                    rbyte_en,
  output logic [7:0]              rbyte,
  output logic                    rbyte_vld,
  output logic                    acc_err,
  input  logic [NTACH*TACH_W-1:0] tach_i,
  input  logic [NFAN*DUTY_W-1:0]  duty_i,
  output logic [7:0]              glob_cfg,
  output logic [7:0]              pwm_freq,
  output logic [NFAN*8-1:0]       fan_cfg,
  output logic [NFAN*8-1:0]       fan_dyn,
  output logic [15:0]             fault_status,
  output logic [15:0]             fault_mask,
  output logic [7:0]              fail_opt,
  output logic [NFAN*16-1:0]      pwm_tgt,
  output logic [NFAN*16-1:0]      cnt_tgt,
  output logic [NFAN*8-1:0]       win
);

  logic       acc_wr;
  logic       acc_rd;
  logic [7:0] acc_addr;

  fanctl_ptr u_ptr (
    .clk        (clk),
    .rst        (rst),
    .xfer_start (xfer_start),
    .wbyte_en   (wbyte_en),
    .wbyte      (wbyte),
    .rbyte_en   (rbyte_en),
    .acc_wr     (acc_wr),
    .acc_rd     (acc_rd),
    .acc_addr   (acc_addr)
  );

  fanctl_regs #(.NFAN(NFAN)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .xfer_start   (xfer_start),
    .acc_wr       (acc_wr),
    .acc_addr     (acc_addr),
    .wdata        (wbyte),
    .glob_cfg     (glob_cfg),
    .pwm_freq     (pwm_freq),
    .fan_cfg      (fan_cfg),
    .fan_dyn      (fan_dyn),
    .fault_status (fault_status),
    .fault_mask   (fault_mask),
    .fail_opt     (fail_opt),
    .pwm_tgt      (pwm_tgt),
    .cnt_tgt      (cnt_tgt),
    .win          (win),
    .acc_err      (acc_err)
  );

  fanctl_rdmux #(.NFAN(NFAN), .NTACH(NTACH), .TACH_W(TACH_W), .DUTY_W(DUTY_W)) u_rd (
    .clk          (clk),
    .rst          (rst),
    .acc_rd       (acc_rd),
    .acc_addr     (acc_addr),
    .tach_i       (tach_i),
    .duty_i       (duty_i),
    .glob_cfg     (glob_cfg),
    .pwm_freq     (pwm_freq),
    .fan_cfg      (fan_cfg),
    .fan_dyn      (fan_dyn),
    .fault_status (fault_status),
    .fault_mask   (fault_mask),
    .fail_opt     (fail_opt),
    .pwm_tgt      (pwm_tgt),
    .cnt_tgt      (cnt_tgt),
    .win          (win),
    .rbyte        (rbyte),
    .rbyte_vld    (rbyte_vld)
  );

endmodule

// File: tb/sim_fanctl_regfile.sv
module sim_fanctl_regfile;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         xfer_start = 1'b0;
  logic         wbyte_en = 1'b0;
  logic [7:0]   wbyte = 8'h00;
  logic         rbyte_en = 1'b0;
  logic [7:0]   rbyte;
  logic         rbyte_vld;
  logic         acc_err;
  logic [131:0] tach_i = '0;
  logic [53:0]  duty_i = '0;
  logic [7:0]   glob_cfg, pwm_freq, fail_opt;
  logic [47:0]  fan_cfg, fan_dyn, win;
  logic [15:0]  fault_status, fault_mask;
  logic [95:0]  pwm_tgt, cnt_tgt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  fanctl_regfile u0 (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .wbyte_en(wbyte_en),
    .wbyte(wbyte), .rbyte_en(rbyte_en), .rbyte(rbyte), .rbyte_vld(rbyte_vld),
    .acc_err(acc_err), .tach_i(tach_i), .duty_i(duty_i), .glob_cfg(glob_cfg),
    .pwm_freq(pwm_freq), .fan_cfg(fan_cfg), .fan_dyn(fan_dyn),
    .fault_status(fault_status), .fault_mask(fault_mask), .fail_opt(fail_opt),
    .pwm_tgt(pwm_tgt), .cnt_tgt(cnt_tgt), .win(win)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic begin_wr(input logic [7:0] p);
    @(negedge clk); xfer_start = 1'b1;
    @(negedge clk); xfer_start = 1'b0; wbyte_en = 1'b1; wbyte = p;
    @(negedge clk); wbyte_en = 1'b0;
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk); wbyte_en = 1'b1; wbyte = d;
    @(negedge clk); wbyte_en = 1'b0;
  endtask

  task automatic get(input logic [7:0] e, input string tag);
    exp_t x;
    x.v = e;
    x.tag = tag;
    @(negedge clk); rbyte_en = 1'b1; sb.push_back(x);
    @(negedge clk); rbyte_en = 1'b0;
  endtask

  // monitor: pops the scoreboard on each returned byte
  always @(negedge clk) begin
    if (!rst && rbyte_vld) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12 unexpected byte act=%h exp=none", rbyte);
      end else begin
        exp_t x;
        x = sb.pop_front();
        chk({24'h0, rbyte}, {24'h0, x.v}, x.tag);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog expired act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tach_i[3*11 +: 11]  = 11'h5A7;
    tach_i[11*11 +: 11] = 11'h001;
    duty_i[2*9 +: 9]    = 9'h1A5;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(glob_cfg, 8'h20, "R1 glob_cfg");
    chk(pwm_freq, 8'h44, "R1 pwm_freq");
    chk(fail_opt, 8'h45, "R1 fail_opt");
    chk(fan_dyn, {6{8'h4C}}, "R1 fan_dyn");
    chk(fan_cfg, 48'h0, "R1 fan_cfg");
    chk(pwm_tgt[31:0], {2{16'h4000}}, "R1 pwm_tgt");
    chk(cnt_tgt[95:64], {2{16'h3D60}}, "R1 cnt_tgt");
    chk(acc_err, 1'b0, "R1 acc_err");
    get(8'h20, "R1 R3 first read at 0x00");
    get(8'h44, "R5 R12 second read at 0x01");

    // R2 R3 R13 pointer then two writes
    begin_wr(8'h02);
    chk(glob_cfg, 8'h20, "R2 pointer byte not stored");
    put(8'hA1);
    chk(fan_cfg[7:0], 8'hA1, "R3 R13 first write at pointer");
    put(8'hB2);
    chk(fan_cfg[15:8], 8'hB2, "R3 advanced write");

    // R4 row wrap 0x07 -> 0x00
    begin_wr(8'h06);
    put(8'h11); put(8'h22); put(8'h33);
    chk(fan_cfg[47:40], 8'h22, "R4 write at 0x07");
    chk(glob_cfg, 8'h33, "R4 wrap to 0x00");
    chk(pwm_freq, 8'h44, "R4 0x01 untouched");

    // R5 R10 read wrap 0xFF -> 0x00
    begin_wr(8'hFE);
    get(8'hFF, "R10 read 0xFE");
    get(8'hFF, "R10 read 0xFF");
    get(8'h33, "R5 wrap to 0x00");

    // R7 partial 16-bit writes
    begin_wr(8'h41);
    put(8'h5A);
    chk(pwm_tgt[15:0], 16'h405A, "R7 low byte only");
    begin_wr(8'h52);
    put(8'h12);
    chk(cnt_tgt[31:16], 16'h1260, "R7 high byte only");
    put(8'h34);
    chk(cnt_tgt[31:16], 16'h1234, "R7 both bytes");
    begin_wr(8'h52);
    get(8'h12, "R7 R6 read high");
    get(8'h34, "R7 R6 read low");

    // R8 tach alignment
    begin_wr(8'h1E);
    get(8'hB4, "R8 tach3 high");
    get(8'hE0, "R8 tach3 low");
    begin_wr(8'h2E);
    get(8'h00, "R8 tach11 high");
    get(8'h20, "R8 tach11 low");

    // R9 duty alignment
    begin_wr(8'h34);
    get(8'hD2, "R9 duty2 high");
    get(8'h80, "R9 duty2 low");

    // R11 write to read-only tach
    begin_wr(8'h1E);
    put(8'h55);
    chk(acc_err, 1'b1, "R11 read-only write flagged");
    begin_wr(8'h1E);
    chk(acc_err, 1'b0, "R11 flag cleared by start");
    get(8'hB4, "R11 tach unchanged");

    // R11 R10 unmapped write and read
    begin_wr(8'h15);
    put(8'h66);
    chk(acc_err, 1'b1, "R11 unmapped write flagged");
    chk(fail_opt, 8'h45, "R11 neighbour untouched");
    begin_wr(8'h15);
    get(8'hFF, "R10 unmapped read 0x15");

    // R6 fault, mask, options row
    begin_wr(8'h10);
    put(8'h01); put(8'h02); put(8'h03); put(8'h04); put(8'h99);
    chk(fault_status, 16'h0102, "R6 fault status");
    chk(fault_mask, 16'h0304, "R6 fault mask");
    chk(fail_opt, 8'h99, "R6 failed-fan options");

    // R6 window
    begin_wr(8'h65);
    put(8'h77);
    chk(win[47:40], 8'h77, "R6 window 5");
    begin_wr(8'h65);
    get(8'h77, "R6 read window 5");

    // R4 R11 dynamics row with holes and wrap
    begin_wr(8'h0D);
    put(8'hC3); put(8'h00); put(8'h00); put(8'h9A);
    chk(fan_dyn[47:40], 8'hC3, "R6 dyn 5");
    chk(fan_dyn[7:0], 8'h9A, "R4 wrap to 0x08");
    chk(acc_err, 1'b1, "R11 sticky through row");

    repeat (4) @(negedge clk);
    chk(sb.size(), 0, "R12 all reads returned");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule